// File: doc/BRIEF.md
# Tag RAM Test-Mode Access Controller

This block gives a host bus direct access to a tag memory while the chip sits in a test mode. The host reaches it through a small window of byte offsets, using a write strobe, a read strobe, an address and a 32-bit data word. Inside the block there are three registers: a 6-bit line counter, a 7-bit segment selector and a 26-bit pattern register. The memory model holds 4 implemented segments of 64 lines, each 26 bits wide. The segment field can name 128 segments, but only the first 4 exist.

A session runs in a fixed order. The host first writes the mode word to enter test mode. It then sets the line and the segment, and loads a pattern. After that, each commit access stores the pattern at the selected line. The counter then steps forward, and the pattern is either bit-flipped or incremented, depending on the offset used. Each fetch access returns the selected line and steps the counter. Setting address bit 7 turns a commit or fetch offset into a burst alias: every beat repeats the operation, so a whole segment can be filled or dumped with one address phase.

Control is a three-state machine:
- `ST_OFF`: test mode is off and every window access is ignored.
- `ST_SETUP`: test mode is on, but the line and the segment have not both been set since entry.
- `ST_READY`: commits and fetches take effect.

Transitions:
- enter: `ST_OFF` to `ST_SETUP`, on mode word 2.
- arm: `ST_SETUP` to `ST_READY`, once both the line and the segment have been set.
- leave: `ST_SETUP` or `ST_READY` to `ST_OFF`, on mode word 0.

Top module: `tagram_tmode_ctrl`

## Requirements
- R1: After reset, `test_active` is 0 and `bus_rdata` is 0.
- R2: A write of value 2 to offset 0x00 enters test mode (`test_active` goes to 1). A write of value 0 to offset 0x00 leaves it. Any other value written to 0x00 changes nothing.
- R3: Outside test mode, every window access is ignored. After entry, commits and fetches are also ignored until both the line (0x04) and the segment (0x08) have been written. While ignored, a fetch returns 0 and the line counter does not move.
- R4: A write to 0x04 loads the line counter from data bits 5:0. Each commit or fetch that takes effect then adds 1 to the counter, and the counter wraps from 63 to 0.
- R5: A write to 0x10 stores the pattern at the current segment and line, then replaces the pattern with its bitwise inverse.
- R6: A write to 0x14 stores the pattern at the current segment and line, then adds 1 to the pattern modulo 2^26.
- R7: A read at 0x18 returns the stored 26-bit line on `bus_rdata[31:6]`, with bits 5:0 at 0. Whenever no read strobe is active, `bus_rdata` is 0.
- R8: A write to 0x0C loads the pattern from data fields as follows: bits 28:24 go to pattern 25:21, bits 22:16 to 20:14, bits 14:8 to 13:7, and bits 6:0 to 6:0. Bits 31:29, 23, 15 and 7 are ignored.
- R9: With address bit 7 set, offsets 0x10, 0x14 and 0x18 (that is, 0x90, 0x94 and 0x98) repeat their operation on every beat of a held strobe. With bit 7 set on offsets 0x00 to 0x0C, the access is ignored.
- R10: When the segment is 4 or higher, commits leave the array unchanged and fetches return 0, but the line counter still advances.
- R11: A write to 0x08 loads the segment from data bits 6:0, and higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe; one operation per cycle while high |
| bus_rd | input | 1 | Read strobe; one operation per cycle while high |
| bus_addr | input | 8 | Window offset; bit 7 selects the burst alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| test_active | output | 1 | High while test mode is on |

## Verification
The bench builds the block with its default sizes: 4 implemented segments, 64 lines and a 26-bit pattern. These are small enough that every line of every segment is filled by a burst of incrementing commits and then read back with a burst of fetches. That sweep also brings the counter's wrap from 63 to 0, the inversion across that wrap, and the pattern's wrap from all ones to zero within a few beats. Because the segment field is wider than the implemented count, out-of-range segments, ignored data bits and ignored burst aliases can all be checked against lines whose contents are already known.

// File: rtl/tagram_tm_pkg.sv
package tagram_tm_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int PAT_W    = 26;
    localparam int IDX_W    = 6;
    localparam int SEG_W    = 7;
    localparam int SEG_IMPL = 4;

    // address bit that selects the repeat alias of an offset
    localparam int BURST_BIT = 7;

    localparam logic [6:0] OFS_MODE    = 7'h00;
    localparam logic [6:0] OFS_LINE    = 7'h04;
    localparam logic [6:0] OFS_SEGMENT = 7'h08;
    localparam logic [6:0] OFS_PATTERN = 7'h0C;
    localparam logic [6:0] OFS_PUT_INV = 7'h10;
    localparam logic [6:0] OFS_PUT_INC = 7'h14;
    localparam logic [6:0] OFS_FETCH   = 7'h18;

    localparam logic [31:0] MODE_ENTER = 32'd2;
    localparam logic [31:0] MODE_LEAVE = 32'd0;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MODE,
        OP_SET_LINE,
        OP_SET_SEG,
        OP_SET_PAT,
        OP_PUT_INV,
        OP_PUT_INC,
        OP_FETCH
    } tm_op_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SETUP,
        ST_READY
    } tm_state_e;

    // gather the four pattern fields out of the bus word
    function automatic logic [25:0] gather_pattern(input logic [31:0] w);
        logic [25:0] p;
        p[25:21] = w[28:24];
        p[20:14] = w[22:16];
        p[13:7]  = w[14:8];
        p[6:0]   = w[6:0];
        return p;
    endfunction

endpackage

// File: rtl/tagram_tm_decode.sv
module tagram_tm_decode
    import tagram_tm_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output tm_op_e        op
);

    logic       rep;
    logic [6:0] base;

    always_comb begin
        rep  = addr[BURST_BIT];
        base = addr[6:0];
        op   = OP_NONE;
        if (wr) begin
            unique case (base)
                OFS_MODE:    op = rep ? OP_NONE : OP_MODE;
                OFS_LINE:    op = rep ? OP_NONE : OP_SET_LINE;
                OFS_SEGMENT: op = rep ? OP_NONE : OP_SET_SEG;
                OFS_PATTERN: op = rep ? OP_NONE : OP_SET_PAT;
                OFS_PUT_INV: op = OP_PUT_INV;
                OFS_PUT_INC: op = OP_PUT_INC;
                default:     op = OP_NONE;
            endcase
        end else if (rd && base == OFS_FETCH) begin
            op = OP_FETCH;
        end
    end

endmodule

// File: rtl/tagram_tm_regs.sv
module tagram_tm_regs
    import tagram_tm_pkg::*;
#(
    parameter int LW = IDX_W,
    parameter int SW = SEG_W,
    parameter int PW = PAT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_line,
    input  logic          set_seg,
    input  logic          set_pat,
    input  logic          step_line,
    input  logic          pat_flip,
    input  logic          pat_bump,
    input  logic [DW-1:0] wdata,
    output logic [LW-1:0] line_q,
    output logic [SW-1:0] seg_q,
    output logic [PW-1:0] pat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (set_line) begin
            line_q <= wdata[LW-1:0];
        end else if (step_line) begin
            line_q <= line_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (set_seg) begin
            seg_q <= wdata[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (set_pat) begin
            pat_q <= PW'(gather_pattern(wdata[31:0]));
        end else if (pat_flip) begin
            pat_q <= ~pat_q;
        end else if (pat_bump) begin
            pat_q <= pat_q + 1'b1;
        end
    end

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_line && !set_line) |=> (line_q == LW'($past(line_q) + 1'b1))); // R4

    AST_PAT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_flip && !set_pat) |=> (pat_q == ~$past(pat_q))); // R5

    AST_PAT_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_bump && !pat_flip && !set_pat) |=> (pat_q == PW'($past(pat_q) + 1'b1))); // R6

endmodule

// File: rtl/tagram_tm_array.sv
module tagram_tm_array #(
    parameter int NSEG = 4,
    parameter int LW   = 6,
    parameter int SW   = 7,
    parameter int PW   = 26
) (
    input  logic          clk,
    input  logic          put,
    input  logic [SW-1:0] seg,
    input  logic [LW-1:0] line,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata
);

    localparam int LINES  = 1 << LW;
    localparam int SEL_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int ENTRIES = NSEG * LINES;
    localparam int AW     = SEL_W + LW;

    logic [PW-1:0] cells [ENTRIES];
    logic          seg_ok;
    logic [AW-1:0] slot;

    assign seg_ok = (seg < SW'(NSEG));
    assign slot   = {seg[SEL_W-1:0], line};

    always_ff @(posedge clk) begin
        if (put && seg_ok) begin
            cells[slot] <= wdata;
        end
    end

    assign rdata = seg_ok ? cells[slot] : '0;

endmodule

// File: rtl/tagram_tmode_ctrl.sv
module tagram_tmode_ctrl
    import tagram_tm_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int PW   = PAT_W,
    parameter int LW   = IDX_W,
    parameter int SW   = SEG_W,
    parameter int NSEG = SEG_IMPL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          test_active
);

    localparam int LOW_W = DW - PW;

    tm_op_e    op;
    tm_state_e state_q, state_d;
    logic      line_seen_q, seg_seen_q;
    logic      line_seen_d, seg_seen_d;

    logic      live, armed;
    logic      set_line, set_seg, set_pat;
    logic      step_line, pat_flip, pat_bump, put;
    logic      fetch;

    logic [LW-1:0] line_q;
    logic [SW-1:0] seg_q;
    logic [PW-1:0] pat_q;
    logic [PW-1:0] cell_rd;

    tagram_tm_decode #(.AW(AW)) u_decode (
        .wr   (bus_wr),
        .rd   (bus_rd),
        .addr (bus_addr),
        .op   (op)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            line_seen_q <= 1'b0;
            seg_seen_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            line_seen_q <= line_seen_d;
            seg_seen_q  <= seg_seen_d;
        end
    end

    // next state
    always_comb begin
        state_d     = state_q;
        line_seen_d = line_seen_q;
        seg_seen_d  = seg_seen_q;
        unique case (state_q)
            ST_OFF: begin
                if (op == OP_MODE && bus_wdata == DW'(MODE_ENTER)) begin
                    state_d     = ST_SETUP;    // enter
                    line_seen_d = 1'b0;
                    seg_seen_d  = 1'b0;
                end
            end
            ST_SETUP: begin
                if (op == OP_MODE && bus_wdata == DW'(MODE_LEAVE)) begin
                    state_d = ST_OFF;          // leave
                end else begin
                    if (op == OP_SET_LINE) line_seen_d = 1'b1;
                    if (op == OP_SET_SEG)  seg_seen_d  = 1'b1;
                    if (line_seen_d && seg_seen_d) begin
                        state_d = ST_READY;    // arm
                    end
                end
            end
            ST_READY: begin
                if (op == OP_MODE && bus_wdata == DW'(MODE_LEAVE)) begin
                    state_d = ST_OFF;          // leave
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        live      = (state_q != ST_OFF);
        armed     = (state_q == ST_READY);
        set_line  = live && (op == OP_SET_LINE);
        set_seg   = live && (op == OP_SET_SEG);
        set_pat   = live && (op == OP_SET_PAT);
        put       = armed && (op == OP_PUT_INV || op == OP_PUT_INC);
        fetch     = armed && (op == OP_FETCH);
        step_line = put || fetch;
        pat_flip  = armed && (op == OP_PUT_INV);
        pat_bump  = armed && (op == OP_PUT_INC);
        test_active = live;
        bus_rdata = fetch ? {cell_rd, {LOW_W{1'b0}}} : '0;
    end

    tagram_tm_regs #(.LW(LW), .SW(SW), .PW(PW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_line  (set_line),
        .set_seg   (set_seg),
        .set_pat   (set_pat),
        .step_line (step_line),
        .pat_flip  (pat_flip),
        .pat_bump  (pat_bump),
        .wdata     (bus_wdata),
        .line_q    (line_q),
        .seg_q     (seg_q),
        .pat_q     (pat_q)
    );

    tagram_tm_array #(.NSEG(NSEG), .LW(LW), .SW(SW), .PW(PW)) u_array (
        .clk   (clk),
        .put   (put),
        .seg   (seg_q),
        .line  (line_q),
        .wdata (pat_q),
        .rdata (cell_rd)
    );

    AST_ENTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_active && op == OP_MODE && bus_wdata == DW'(MODE_ENTER)) |=> test_active); // R2

    AST_LEAVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MODE && bus_wdata == DW'(MODE_LEAVE)) |=> !test_active); // R2

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R7

    AST_NO_PUT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_OFF && state_q == ST_SETUP) |-> !put); // R3

endmodule

// File: tb/tagram_tmode_ctrl_tb.sv
module tagram_tmode_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        test_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] got [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    tagram_tmode_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .test_active (test_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // hold the write strobe for n beats
    task automatic wr_beats(input logic [7:0] a, input logic [31:0] d, input int n);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        repeat (n) @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // hold the read strobe for n beats, sampling each mid-cycle
    task automatic rd_beats(input logic [7:0] a, input int n);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        for (int i = 0; i < n; i++) begin
            #1 got[i] = bus_rdata;
            @(negedge clk);
        end
        bus_rd = 1'b0;
    endtask

    // build a bus word for pattern p, with every ignored bit set
    function automatic logic [31:0] word_of(input logic [25:0] p);
        return {3'b111, p[25:21], 1'b1, p[20:14], 1'b1, p[13:7], 1'b1, p[6:0]};
    endfunction

    function automatic logic [25:0] base_of(input int s);
        return 26'h0123456 + 26'(s) * 26'h0400001;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [25:0] p;
        repeat (3) @(negedge clk);
        #1;
        check("R1 test_active", {31'b0, test_active}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;

        wr_beats(8'h00, 32'd2, 1);
        #1 check("R2 enter", {31'b0, test_active}, 32'd1);

        // full sweep: every line of every segment, burst increment then burst read (R9, R6, R7)
        for (int s = 0; s < 4; s++) begin
            wr_beats(8'h04, 32'd0, 1);
            wr_beats(8'h08, 32'(s), 1);
            wr_beats(8'h0C, word_of(base_of(s)), 1);
            wr_beats(8'h94, 32'd0, 64);
            wr_beats(8'h04, 32'd0, 1);
            rd_beats(8'h98, 64);
            for (int i = 0; i < 64; i++)
                check("R6 R9 sweep", got[i], {base_of(s) + 26'(i), 6'b0});
            // counter wrapped 63 -> 0 (R4)
            rd_beats(8'h18, 1);
            check("R4 wrap", got[0], {base_of(s), 6'b0});
        end

        // packing and inversion, R8 and R5
        p = 26'h25A6C3B;
        wr_beats(8'h08, 32'd3, 1);
        wr_beats(8'h04, 32'd40, 1);
        wr_beats(8'h0C, word_of(p), 1);
        wr_beats(8'h10, 32'd0, 1);
        wr_beats(8'h10, 32'd0, 1);
        wr_beats(8'h04, 32'd40, 1);
        rd_beats(8'h98, 3);
        check("R8 packing", got[0], {p, 6'b0});
        check("R5 invert", got[1], {~p, 6'b0});
        check("R5 next line untouched", got[2], {base_of(3) + 26'd42, 6'b0});

        // inversion across the counter wrap, burst alias of 0x10 (R4 R5 R9)
        p = 26'h0F0F0F0;
        wr_beats(8'h08, 32'd2, 1);
        wr_beats(8'h04, 32'd63, 1);
        wr_beats(8'h0C, word_of(p), 1);
        wr_beats(8'h90, 32'd0, 3);
        wr_beats(8'h04, 32'd63, 1);
        rd_beats(8'h98, 3);
        check("R5 R9 line63", got[0], {p, 6'b0});
        check("R4 R5 line0", got[1], {~p, 6'b0});
        check("R5 line1", got[2], {p, 6'b0});

        // pattern increment wraps modulo 2^26 (R6)
        wr_beats(8'h08, 32'd1, 1);
        wr_beats(8'h04, 32'd20, 1);
        wr_beats(8'h0C, word_of(26'h3FFFFFF), 1);
        wr_beats(8'h94, 32'd0, 2);
        wr_beats(8'h04, 32'd20, 1);
        rd_beats(8'h98, 2);
        check("R6 all ones", got[0], {26'h3FFFFFF, 6'b0});
        check("R6 wrap to zero", got[1], 32'd0);

        // out-of-range segment with stray upper bit (R10 R11)
        wr_beats(8'h08, 32'h0000_0105, 1);
        wr_beats(8'h04, 32'hFFFF_FFCA, 1);   // line 10, upper bits ignored
        rd_beats(8'h18, 1);
        check("R10 read zero", got[0], 32'd0);
        wr_beats(8'h14, 32'd0, 1);
        wr_beats(8'h08, 32'h0000_0100, 1);   // segment 0
        rd_beats(8'h18, 1);
        check("R10 R11 line advanced", got[0], {base_of(0) + 26'd12, 6'b0});
        wr_beats(8'h08, 32'd1, 1);
        wr_beats(8'h04, 32'd10, 1);
        rd_beats(8'h18, 1);
        check("R10 write discarded", got[0], {base_of(1) + 26'd10, 6'b0});

        // burst alias of a set offset is ignored (R9)
        wr_beats(8'h84, 32'd30, 1);
        wr_beats(8'h88, 32'd3, 1);
        rd_beats(8'h18, 1);
        check("R9 alias ignored", got[0], {base_of(1) + 26'd11, 6'b0});

        // leave, then accesses are ignored (R2 R3)
        wr_beats(8'h00, 32'd0, 1);
        #1 check("R2 leave", {31'b0, test_active}, 32'd0);
        wr_beats(8'h08, 32'd0, 1);
        wr_beats(8'h04, 32'd0, 1);
        wr_beats(8'h14, 32'd0, 1);
        rd_beats(8'h18, 1);
        check("R3 read off", got[0], 32'd0);
        wr_beats(8'h00, 32'd3, 1);
        #1 check("R2 other value", {31'b0, test_active}, 32'd0);

        // re-entry needs both line and segment (R3)
        wr_beats(8'h00, 32'd2, 1);
        wr_beats(8'h00, 32'd5, 1);
        #1 check("R2 other value in mode", {31'b0, test_active}, 32'd1);
        wr_beats(8'h04, 32'd0, 1);
        rd_beats(8'h18, 1);
        check("R3 not armed", got[0], 32'd0);
        wr_beats(8'h08, 32'd0, 1);
        rd_beats(8'h18, 1);
        check("R3 armed line0 intact", got[0], {base_of(0), 6'b0});
        rd_beats(8'h18, 1);
        check("R3 R4 no step while unarmed", got[0], {base_of(0) + 26'd1, 6'b0});
        #1 check("R7 idle rdata", bus_rdata, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule